// File: doc/BRIEF.md
# Glitch-Free Dual Clock Switch with Leaf Divider

This block picks one of two free-running clocks and passes it to a single switched clock net. Changing from one source to the other never produces a runt pulse. Each source has its own select and its own enable, and a source drives the output only while both are active.

A handover first parks the outgoing source at the idle level on that source's own idle edge. The incoming source may start only after the outgoing source's handshake chain has fully cleared. A per-source skip input lets the output leave that source at once, without waiting for a safe point.

Parameters set the following:
- the idle level;
- a power-up preselection;
- an optional three-flop synchronizer on each enable;
- a polarity inversion for every clock and control pin.

The switched clock drives a small counter, which produces the clock divided by 1, 2, 4 and 8. An active-low clear resets that counter.

Top module: `clk_switch_leaf`

## Requirements
- R1: The switched output equals the clock of the source that is both selected and enabled, once the handover has settled (after 2 idle edges of the incoming source, plus up to 2 of the outgoing one).
- R2: Without skip, no high or low pulse on `clk_div1` is shorter than the shorter of the two source half-periods, across any sequence of select changes.
- R3: When both sources are selected and enabled from reset without preselection, source A drives the output and source B stays parked.
- R4: With `skip_a` active, dropping `sel_a` while `clk_a` is high forces the output to the idle level in the same instant. With `skip_a` inactive, the output finishes the current high phase and parks on the next falling edge of `clk_a`.
- R5: A source that is selected but not enabled never reaches the output; the output rests at the idle level.
- R6: With no source granted, including during reset without preselection, the output is held at `IDLE_LEVEL`. Switching in that mode happens on the edge that returns each source to that level.
- R7: A source marked in `PRESEL` drives the output while reset is asserted and keeps driving it after release, with no handshake. If both are marked, A wins.
- R8: With the hard synchronizer on an enable, the output shows no edge from that source during the first 4 idle edges of the source after the enable changes. It follows the source by the 8th such edge.
- R9: Each bit of `INV_CLK`, `INV_SEL`, `INV_EN` and `INV_SKIP` (bit 0 for source A, bit 1 for source B) inverts that pin before use. With `INV_EN[0]=1`, a low `en_a` enables source A.
- R10: Over any 64 rising edges of `clk_div1`, `clk_div2` rises 32 times, `clk_div4` 16 times and `clk_div8` 8 times.
- R11: While `leaf_clr_n` is low, `clk_div2`, `clk_div4` and `clk_div8` stay low and `clk_div1` keeps running.
- R12: The two sources are never granted at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Source clock A (priority source) |
| clk_b | input | 1 | Source clock B |
| rst_n | input | 1 | Active-low asynchronous reset of all switch and divider state |
| sel_a | input | 1 | Select for source A |
| sel_b | input | 1 | Select for source B |
| en_a | input | 1 | Enable for source A |
| en_b | input | 1 | Enable for source B |
| skip_a | input | 1 | Leave source A at once when it loses its request |
| skip_b | input | 1 | Leave source B at once when it loses its request |
| leaf_clr_n | input | 1 | Active-low clear of the leaf divider |
| clk_div1 | output | 1 | Switched clock |
| clk_div2 | output | 1 | Switched clock divided by 2 |
| clk_div4 | output | 1 | Switched clock divided by 4 |
| clk_div8 | output | 1 | Switched clock divided by 8 |

## Verification
A handshake chain stuck high or released too early shows at the ports within one period of the slower source: either two sources are mixed, which gives a pulse shorter than a source half-period, or the output stays parked instead of following the new source. A wrong synchronizer depth or a missing inversion moves the first output edge by one or more source periods, or stops it altogether. A divider fault changes the edge count of `clk_div2`, `clk_div4` or `clk_div8` over the next 64 switched-clock edges.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    // enable synchronizer depth and safe-switch handshake depth
    localparam int SYNC_STAGES = 3;
    localparam int HS_STAGES   = 2;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [HS_STAGES-1:0]   chain;
    } leg_next_t;

    function automatic logic pol(input logic v, input bit inv);
        return v ^ inv;
    endfunction

endpackage

// File: rtl/clksw_leg.sv
// One source of the switch: optional enable synchronizer plus the
// handshake chain, all clocked on the source's return-to-idle edge.
module clksw_leg
    import clksw_pkg::*;
#(
    parameter bit HARD_SYNC = 1'b0,
    parameter bit PRESEL    = 1'b0
) (
    input  logic clk_n,      // normalized source clock, flops use its falling edge
    input  logic rst_n,
    input  logic sel,
    input  logic en,
    input  logic skip,
    input  logic block,      // higher-priority source is requesting
    input  logic other_busy, // other source's chain not yet empty
    output logic want,
    output logic grant,
    output logic busy
);

    localparam logic [SYNC_STAGES-1:0] SYNC_RST  = PRESEL ? '1 : '0;
    localparam logic [HS_STAGES-1:0]   CHAIN_RST = PRESEL ? '1 : '0;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [HS_STAGES-1:0]   chain_q;
    leg_next_t              nxt_d;
    logic                   en_eff;
    logic                   req;
    logic                   drop;

    always_comb begin
        nxt_d.sync  = {sync_q[SYNC_STAGES-2:0], en};
        en_eff      = HARD_SYNC ? sync_q[SYNC_STAGES-1] : en;
        want        = sel & en_eff;
        req         = want & ~block;
        drop        = skip & ~req;
        nxt_d.chain = {chain_q[HS_STAGES-2:0], req & ~other_busy};
    end

    always_ff @(negedge clk_n or negedge rst_n) begin
        if (!rst_n) sync_q <= SYNC_RST;
        else        sync_q <= nxt_d.sync;
    end

    // skip path clears the chain without waiting for the idle edge
    always_ff @(negedge clk_n or negedge rst_n or posedge drop) begin
        if (!rst_n)    chain_q <= CHAIN_RST;
        else if (drop) chain_q <= '0;
        else           chain_q <= nxt_d.chain;
    end

    assign grant = &chain_q;
    assign busy  = |chain_q;

endmodule

// File: rtl/clksw_leaf_div.sv
// Binary leaf divider: output i is the input clock divided by 2**i.
module clksw_leaf_div #(
    parameter int OUTS = 4
) (
    input  logic            clk,
    input  logic            clr_n,
    output logic [OUTS-1:0] div
);

    localparam int CW = OUTS - 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_state_t;

    div_state_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign div[0] = clk;
    for (genvar i = 1; i < OUTS; i++) begin : g_tap
        assign div[i] = st_q.cnt[i-1];
    end

endmodule

// File: rtl/clk_switch_leaf.sv
module clk_switch_leaf
    import clksw_pkg::*;
#(
    parameter bit       IDLE_LEVEL = 1'b0,
    parameter bit [1:0] HARD_SYNC  = 2'b00,
    parameter bit [1:0] PRESEL     = 2'b00,
    parameter bit [1:0] INV_CLK    = 2'b00,
    parameter bit [1:0] INV_SEL    = 2'b00,
    parameter bit [1:0] INV_EN     = 2'b00,
    parameter bit [1:0] INV_SKIP   = 2'b00
) (
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst_n,
    input  logic sel_a,
    input  logic sel_b,
    input  logic en_a,
    input  logic en_b,
    input  logic skip_a,
    input  logic skip_b,
    input  logic leaf_clr_n,
    output logic clk_div1,
    output logic clk_div2,
    output logic clk_div4,
    output logic clk_div8
);

    localparam int       NSRC       = 2;
    localparam int       DIV_OUTS   = 4;
    localparam bit [1:0] PRESEL_EFF = PRESEL[0] ? 2'b01 : PRESEL;

    logic [NSRC-1:0] clk_raw, clk_norm, sel_v, en_v, skip_v;
    logic [NSRC-1:0] want, block, grant, busy;
    logic            sw_clk;
    logic [DIV_OUTS-1:0] div;

    for (genvar i = 0; i < NSRC; i++) begin : g_pin
        logic c_in, s_in, e_in, k_in;
        assign c_in = (i == 0) ? clk_a  : clk_b;
        assign s_in = (i == 0) ? sel_a  : sel_b;
        assign e_in = (i == 0) ? en_a   : en_b;
        assign k_in = (i == 0) ? skip_a : skip_b;
        assign clk_raw[i]  = pol(c_in, INV_CLK[i]);
        assign clk_norm[i] = clk_raw[i] ^ IDLE_LEVEL;
        assign sel_v[i]    = pol(s_in, INV_SEL[i]);
        assign en_v[i]     = pol(e_in, INV_EN[i]);
        assign skip_v[i]   = pol(k_in, INV_SKIP[i]);
    end

    // source A has priority over source B
    assign block[0] = 1'b0;
    assign block[1] = want[0];

    for (genvar i = 0; i < NSRC; i++) begin : g_leg
        clksw_leg #(
            .HARD_SYNC (HARD_SYNC[i]),
            .PRESEL    (PRESEL_EFF[i])
        ) u_leg (
            .clk_n      (clk_norm[i]),
            .rst_n      (rst_n),
            .sel        (sel_v[i]),
            .en         (en_v[i]),
            .skip       (skip_v[i]),
            .block      (block[i]),
            .other_busy (busy[NSRC-1-i]),
            .want       (want[i]),
            .grant      (grant[i]),
            .busy       (busy[i])
        );
    end

    assign sw_clk = IDLE_LEVEL ^ (|(clk_norm & grant));

    clksw_leaf_div #(.OUTS(DIV_OUTS)) u_div (
        .clk   (sw_clk),
        .clr_n (leaf_clr_n & rst_n),
        .div   (div)
    );

    assign clk_div1 = div[0];
    assign clk_div2 = div[1];
    assign clk_div4 = div[2];
    assign clk_div8 = div[3];

endmodule

// File: rtl/clk_switch_leaf_chk.sv
module clk_switch_leaf_chk (
    input logic       clk_a,
    input logic       clk_b,
    input logic       rst_n,
    input logic       leaf_clr_n,
    input logic [1:0] grant,
    input logic       clk_div1,
    input logic       clk_div2,
    input logic       clk_div4,
    input logic       clk_div8
);

    // R12
    grant_excl_a_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        !(grant[0] && grant[1]));

    // R12
    grant_excl_b_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
        !(grant[0] && grant[1]));

    // R10
    div2_toggle_chk: assert property (@(posedge clk_div1) disable iff (!rst_n || !leaf_clr_n)
        leaf_clr_n |=> (clk_div2 != $past(clk_div2)));

    // R10
    div4_step_chk: assert property (@(posedge clk_div1) disable iff (!rst_n || !leaf_clr_n)
        clk_div2 |=> (clk_div4 != $past(clk_div4)));

    // R11
    leaf_clear_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        !leaf_clr_n |-> !(clk_div2 || clk_div4 || clk_div8));

endmodule

bind clk_switch_leaf clk_switch_leaf_chk u_chk (
    .clk_a      (clk_a),
    .clk_b      (clk_b),
    .rst_n      (rst_n),
    .leaf_clr_n (leaf_clr_n),
    .grant      (grant),
    .clk_div1   (clk_div1),
    .clk_div2   (clk_div2),
    .clk_div4   (clk_div4),
    .clk_div8   (clk_div8)
);

// File: tb/tb_clk_switch_leaf.sv
`timescale 1ns/1ps
module tb_clk_switch_leaf;

    localparam real HALF_A   = 4.0;   // 125 MHz
    localparam real HALF_B   = 6.5;
    localparam real MIN_HALF = 4.0;

    logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
    // default instance controls
    logic sel_a = 1, sel_b = 1, en_a = 1, en_b = 1, skip_a = 0, skip_b = 0, clr_n = 1;
    // alternate instance controls
    logic asel_a = 0, asel_b = 1, aen_a = 1, aen_b = 1;
    logic d1, d2, d4, d8, a1, a2, a4, a8;

    int checks = 0, errs = 0;

    always #(HALF_A) clk_a = ~clk_a;
    always #(HALF_B) clk_b = ~clk_b;

    clk_switch_leaf dut (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
        .sel_a(sel_a), .sel_b(sel_b), .en_a(en_a), .en_b(en_b),
        .skip_a(skip_a), .skip_b(skip_b), .leaf_clr_n(clr_n),
        .clk_div1(d1), .clk_div2(d2), .clk_div4(d4), .clk_div8(d8));

    // idle high, B preselected, A enable inverted and hard-synchronized
    clk_switch_leaf #(
        .IDLE_LEVEL(1'b1), .HARD_SYNC(2'b01), .PRESEL(2'b10), .INV_EN(2'b01)
    ) dut_alt (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
        .sel_a(asel_a), .sel_b(asel_b), .en_a(aen_a), .en_b(aen_b),
        .skip_a(1'b0), .skip_b(1'b0), .leaf_clr_n(1'b1),
        .clk_div1(a1), .clk_div2(a2), .clk_div4(a4), .clk_div8(a8));

    // edge counters
    int d1_rise = 0, d2_rise = 0, d4_rise = 0, d8_rise = 0, a1_fall = 0;
    always @(posedge d1) d1_rise++;
    always @(posedge d2) d2_rise++;
    always @(posedge d4) d4_rise++;
    always @(posedge d8) d8_rise++;
    always @(negedge a1) a1_fall++;

    // pulse-width monitors
    bit  mon_d = 0, have_d = 0, mon_a = 0, have_a = 0;
    real last_d = 0.0, last_a = 0.0;
    int  glitch_d = 0, glitch_a = 0;
    always @(d1) begin
        if (mon_d && have_d && ($realtime - last_d) < MIN_HALF - 0.01) glitch_d++;
        last_d = $realtime;
        have_d = mon_d;
    end
    always @(a1) begin
        if (mon_a && have_a && ($realtime - last_a) < MIN_HALF - 0.01) glitch_a++;
        last_a = $realtime;
        have_a = mon_a;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // reference: output must equal the chosen source clock level
    task automatic follow(input bit alt, input bit src, input string req);
        for (int k = 0; k < 3; k++) begin
            if (src) @(posedge clk_b); else @(posedge clk_a);
            #1.5;
            chk((alt ? a1 : d1) == (src ? clk_b : clk_a), req,
                alt ? a1 : d1, src ? clk_b : clk_a);
            if (src) @(negedge clk_b); else @(negedge clk_a);
            #1.5;
            chk((alt ? a1 : d1) == (src ? clk_b : clk_a), req,
                alt ? a1 : d1, src ? clk_b : clk_a);
        end
    endtask

    task automatic run();
        int s1, s2, s4, s8, f0;
        // R6 and R7 while reset is held
        #20;
        for (int k = 0; k < 4; k++) begin
            #7.3;
            chk(d1 == 1'b0, "R6 idle during reset", d1, 0);
        end
        follow(1'b1, 1'b1, "R7 preselect during reset");
        #3; rst_n = 1'b1;
        repeat (6) @(posedge clk_b);
        mon_d = 1; mon_a = 1;
        follow(1'b0, 1'b0, "R3 priority to A");
        follow(1'b1, 1'b1, "R7 preselect after reset");

        // R10 divider ratios
        @(posedge d1); #1;
        s1 = d1_rise; s2 = d2_rise; s4 = d4_rise; s8 = d8_rise;
        repeat (64) @(posedge d1);
        #1;
        chk(d1_rise - s1 == 64, "R10 div1 count", d1_rise - s1, 64);
        chk(d2_rise - s2 == 32, "R10 div2 count", d2_rise - s2, 32);
        chk(d4_rise - s4 == 16, "R10 div4 count", d4_rise - s4, 16);
        chk(d8_rise - s8 == 8,  "R10 div8 count", d8_rise - s8, 8);

        // R1 switch to B and back
        sel_a = 1'b0;
        repeat (8) @(posedge clk_b);
        follow(1'b0, 1'b1, "R1 follow B");
        sel_a = 1'b1;
        repeat (8) @(posedge clk_a);
        follow(1'b0, 1'b0, "R1 follow A again");

        // R5 selected but not enabled
        en_a = 1'b0; sel_b = 1'b0;
        repeat (6) @(posedge clk_a);
        #1; s1 = d1_rise;
        repeat (10) @(posedge clk_a);
        #1;
        chk(d1_rise == s1, "R5 no edges when disabled", d1_rise - s1, 0);
        chk(d1 == 1'b0, "R5 idle level when disabled", d1, 0);
        en_a = 1'b1;
        repeat (6) @(posedge clk_a);
        follow(1'b0, 1'b0, "R1 follow A after enable");

        // R4 without skip: high phase completes
        @(posedge clk_a); #1;
        sel_a = 1'b0;
        #1;
        chk(d1 == 1'b1, "R4 no skip keeps phase", d1, 1);
        @(negedge clk_a); #1;
        chk(d1 == 1'b0, "R4 no skip parks at edge", d1, 0);
        s1 = d1_rise;
        repeat (6) @(posedge clk_a);
        #1;
        chk(d1_rise == s1, "R4 no skip stays parked", d1_rise - s1, 0);
        sel_a = 1'b1;
        repeat (6) @(posedge clk_a);
        follow(1'b0, 1'b0, "R1 follow A before skip");

        // R4 with skip: immediate exit
        mon_d = 0;
        skip_a = 1'b1;
        @(posedge clk_a); #1;
        sel_a = 1'b0;
        #0.5;
        chk(d1 == 1'b0, "R4 skip leaves at once", d1, 0);
        @(negedge clk_a); #1;
        skip_a = 1'b0; sel_a = 1'b1; sel_b = 1'b1;
        repeat (6) @(posedge clk_a);
        mon_d = 1;

        // R2 many switches at scattered times
        for (int k = 0; k < 8; k++) begin
            #(23 + k * 7);
            sel_a = ~sel_a;
        end
        repeat (10) @(posedge clk_a);
        follow(1'b0, 1'b0, "R1 follow A after toggling");
        sel_a = 1'b0;
        repeat (8) @(posedge clk_b);
        follow(1'b0, 1'b1, "R1 follow B after toggling");

        // R11 leaf clear
        clr_n = 1'b0;
        @(posedge d1); #1;
        s1 = d1_rise; s2 = d2_rise;
        repeat (20) @(posedge d1);
        #1;
        chk(d2_rise == s2, "R11 div2 frozen", d2_rise - s2, 0);
        chk({d2, d4, d8} == 3'b000, "R11 dividers low", {d2, d4, d8}, 0);
        chk(d1_rise - s1 == 20, "R11 div1 running", d1_rise - s1, 20);
        clr_n = 1'b1;

        // R9 and R6 on the alternate instance: A selected, inverted enable held inactive
        asel_b = 1'b0; asel_a = 1'b1; aen_a = 1'b1;
        repeat (12) @(posedge clk_a);
        #1; f0 = a1_fall;
        repeat (10) @(posedge clk_a);
        #1;
        chk(a1_fall == f0, "R9 inverted enable blocks", a1_fall - f0, 0);
        chk(a1 == 1'b1, "R6 idle high level", a1, 1);

        // R8 hard synchronizer latency
        @(negedge clk_a); #1;
        aen_a = 1'b0;
        f0 = a1_fall;
        repeat (4) @(posedge clk_a);
        #1;
        chk(a1_fall == f0, "R8 no edge in first 4", a1_fall - f0, 0);
        repeat (4) @(posedge clk_a);
        follow(1'b1, 1'b0, "R8 follows by 8th edge");

        // R2 verdicts
        chk(glitch_d == 0, "R2 no short pulse default", glitch_d, 0);
        chk(glitch_a == 0, "R2 no short pulse alternate", glitch_a, 0);
    endtask

    initial begin
        bit wd = 0;
        fork
            run();
            begin #150000; wd = 1; end
        join_any
        if (wd) begin
            checks++; errs++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

endmodule